// File: doc/BRIEF.md
# Raw Pixel Black Level, Gain and Test Pattern Front End

This block sits at the head of a camera pixel pipeline and conditions the raw 10-bit Bayer samples that arrive from the sensor converter. Each sample first has a programmable black offset removed, so that optical black lands on code zero. The result is then scaled by a digital gain between x1 and just under x8, which comes from an exposure controller.

A selector can replace the scaled camera stream with a synthetic picture. Three synthetic pictures are available: vertical colour bars, a ramp and a flat level. After that selector, a second offset stage adds a programmable level back in. This models the adder that follows the shading-correction slot, and in normal use it is left at zero.

The stream is qualified by a frame-valid and a line-valid strobe. Both strobes are delayed to match the two register stages of the datapath. All settings are captured once per frame, when frame-valid rises, so a change made in the middle of a frame never tears the picture.

Top module: `pix_front_cond`

## Requirements
- R1: While reset is asserted, `out_fv`, `out_lv` and `out_pix` are all zero.
- R2: `out_fv` and `out_lv` equal `in_fv` and `in_lv` as they were sampled two clock edges earlier. Each pixel leaves with the strobes of its own input cycle.
- R3: While `out_lv` is low, `out_pix` is zero.
- R4: In camera mode, the black offset is subtracted from the pixel and the difference is clamped at zero when the offset is larger than the pixel.
- R5: The gain code is unsigned, with 3 integer bits and 5 fraction bits, so code 32 means x1. The product is truncated, not rounded. Any code below 32 is applied as x1.
- R6: The scaled camera value saturates at 1023.
- R7: The post offset is added after the pattern selector, in every mode, and the sum saturates at 1023.
- R8: Pattern select codes are: 0 for the camera stream, 1 for colour bars, 2 for the ramp, 3 for the flat level `cfg_pat_level`.
- R9: In the colour bar picture, the bar index is (column >> 3) mod 8. Bar k has level floor(k*1023/7).
- R10: The ramp picture is (column + line) mod 1024. Column counts from 0 at the first valid pixel of each line. Line counts from 0 at the first line of each frame.
- R11: All settings are captured in the cycle where `in_fv` is high after a low cycle, and that cycle already uses the new values. Changes made later in the same frame have no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_fv | input | 1 | Input frame valid |
| in_lv | input | 1 | Input line valid (pixel qualifier) |
| in_pix | input | 10 | Raw sensor sample |
| cfg_black_sub | input | 10 | Black offset removed before gain |
| cfg_gain | input | 8 | Digital gain, unsigned 3.5 fixed point |
| cfg_black_add | input | 10 | Offset added after the pattern selector |
| cfg_pat_sel | input | 2 | Source select: camera, bars, ramp, flat |
| cfg_pat_level | input | 10 | Level of the flat pattern |
| out_fv | output | 1 | Delayed frame valid |
| out_lv | output | 1 | Delayed line valid |
| out_pix | output | 10 | Conditioned pixel |

## Verification
The assertions assume that the inputs carry no unknown values once reset is released. They also assume that line-valid is raised only inside frame-valid, and that each frame is preceded by at least one cycle with frame-valid low, so that the capture of settings is actually triggered. The stimulus meets these conditions by building every frame from one task: frame-valid is raised two cycles before the first line, dropped after the last, and held low for several cycles between frames. Settings changes are applied only in the gaps between lines, or before frame-valid rises.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
   typedef enum logic [1:0] {
      PAT_CAMERA = 2'd0,
      PAT_BARS   = 2'd1,
      PAT_RAMP   = 2'd2,
      PAT_FLAT   = 2'd3
   } pat_sel_e;
endpackage

// File: rtl/pfc_frame_regs.sv
// Per-frame capture of the settings; the capture cycle itself sees the new values.
module pfc_frame_regs
   import pfc_pkg::*;
#(
   parameter int PIX_W     = 10,
   parameter int GAIN_W    = 8,
   parameter int GAIN_FRAC = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [PIX_W-1:0]  cfg_sub,
   input  logic [GAIN_W-1:0] cfg_gain,
   input  logic [PIX_W-1:0]  cfg_add,
   input  pat_sel_e          cfg_sel,
   input  logic [PIX_W-1:0]  cfg_level,
   output logic [PIX_W-1:0]  eff_sub,
   output logic [GAIN_W-1:0] eff_gain,
   output logic [PIX_W-1:0]  eff_add,
   output pat_sel_e          eff_sel,
   output logic [PIX_W-1:0]  eff_level
);
   localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1 << GAIN_FRAC);

   logic [PIX_W-1:0]  hold_sub, hold_add, hold_level;
   logic [GAIN_W-1:0] hold_gain;
   pat_sel_e          hold_sel;
   logic [GAIN_W-1:0] floor_gain;

   assign floor_gain = (cfg_gain < GAIN_ONE) ? GAIN_ONE : cfg_gain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_sub   <= '0;
         hold_gain  <= GAIN_ONE;
         hold_add   <= '0;
         hold_sel   <= PAT_CAMERA;
         hold_level <= '0;
      end else if (frame_start) begin
         hold_sub   <= cfg_sub;
         hold_gain  <= floor_gain;
         hold_add   <= cfg_add;
         hold_sel   <= cfg_sel;
         hold_level <= cfg_level;
      end
   end

   always_comb begin
      if (frame_start) begin
         eff_sub   = cfg_sub;
         eff_gain  = floor_gain;
         eff_add   = cfg_add;
         eff_sel   = cfg_sel;
         eff_level = cfg_level;
      end else begin
         eff_sub   = hold_sub;
         eff_gain  = hold_gain;
         eff_add   = hold_add;
         eff_sel   = hold_sel;
         eff_level = hold_level;
      end
   end
endmodule

// File: rtl/pfc_gain_stage.sv
// Offset removal clamped at zero, fixed-point scale, saturation to full scale.
module pfc_gain_stage #(
   parameter int PIX_W     = 10,
   parameter int GAIN_W    = 8,
   parameter int GAIN_FRAC = 5
) (
   input  logic [PIX_W-1:0]  pix,
   input  logic [PIX_W-1:0]  black,
   input  logic [GAIN_W-1:0] gain,
   output logic [PIX_W-1:0]  result
);
   localparam int PROD_W  = PIX_W + GAIN_W;
   localparam int SCALE_W = PROD_W - GAIN_FRAC;
   localparam logic [PIX_W-1:0] PIX_MAX = '1;

   logic [PIX_W-1:0]   lifted;
   logic [PROD_W-1:0]  prod;
   logic [SCALE_W-1:0] scaled;

   always_comb begin
      lifted = (pix > black) ? (pix - black) : '0;
      prod   = PROD_W'(lifted) * PROD_W'(gain);
      scaled = prod[PROD_W-1:GAIN_FRAC];
      result = (scaled > SCALE_W'(PIX_MAX)) ? PIX_MAX : scaled[PIX_W-1:0];
   end
endmodule

// File: rtl/pfc_pattern_gen.sv
// Synthetic pictures driven from a column counter and a line counter.
module pfc_pattern_gen
   import pfc_pkg::*;
#(
   parameter int PIX_W     = 10,
   parameter int CNT_W     = 12,
   parameter int BAR_SHIFT = 3,
   parameter int NUM_BARS  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_fv,
   input  logic             in_lv,
   input  pat_sel_e         sel,
   input  logic [PIX_W-1:0] level,
   output logic [PIX_W-1:0] pat_pix
);
   localparam int BAR_IDX_W = $clog2(NUM_BARS);
   localparam int PIX_MAX   = (1 << PIX_W) - 1;

   logic [CNT_W-1:0]     col, line, ramp_sum;
   logic                 lv_q;
   logic [BAR_IDX_W-1:0] bar_idx;
   logic [PIX_W-1:0]     bar_lvl [NUM_BARS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col  <= '0;
         line <= '0;
         lv_q <= 1'b0;
      end else begin
         lv_q <= in_lv;
         col  <= in_lv ? col + 1'b1 : '0;
         if (!in_fv)
            line <= '0;
         else if (lv_q && !in_lv)
            line <= line + 1'b1;
      end
   end

   for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
      assign bar_lvl[b] = PIX_W'((b * PIX_MAX) / (NUM_BARS - 1));
   end

   assign bar_idx  = col[BAR_SHIFT +: BAR_IDX_W];
   assign ramp_sum = col + line;

   always_comb begin
      case (sel)
         PAT_BARS: pat_pix = bar_lvl[bar_idx];
         PAT_RAMP: pat_pix = ramp_sum[PIX_W-1:0];
         PAT_FLAT: pat_pix = level;
         default:  pat_pix = '0;
      endcase
   end
endmodule

// File: rtl/pix_front_cond.sv
module pix_front_cond
   import pfc_pkg::*;
#(
   parameter int PIX_W        = 10,
   parameter int GAIN_W       = 8,
   parameter int GAIN_FRAC    = 5,
   parameter int CNT_W        = 12,
   parameter int BAR_SHIFT    = 3,
   parameter int NUM_BARS     = 8,
   parameter bit POST_ADD_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_fv,
   input  logic              in_lv,
   input  logic [PIX_W-1:0]  in_pix,
   input  logic [PIX_W-1:0]  cfg_black_sub,
   input  logic [GAIN_W-1:0] cfg_gain,
   input  logic [PIX_W-1:0]  cfg_black_add,
   input  logic [1:0]        cfg_pat_sel,
   input  logic [PIX_W-1:0]  cfg_pat_level,
   output logic              out_fv,
   output logic              out_lv,
   output logic [PIX_W-1:0]  out_pix
);
   localparam int BAR_IDX_W = $clog2(NUM_BARS);

   if (GAIN_FRAC >= GAIN_W) begin : g_bad_gain
      $error("pix_front_cond: GAIN_FRAC must be below GAIN_W");
   end
   if (NUM_BARS < 2 || (NUM_BARS & (NUM_BARS - 1)) != 0) begin : g_bad_bars
      $error("pix_front_cond: NUM_BARS must be a power of two, at least 2");
   end
   if (CNT_W < PIX_W || CNT_W < BAR_SHIFT + BAR_IDX_W) begin : g_bad_cnt
      $error("pix_front_cond: CNT_W too narrow");
   end

   logic             fv_q, frame_start;
   logic [PIX_W-1:0] eff_sub, eff_add, eff_level, cam_pix, pat_pix, post_sum;
   logic [GAIN_W-1:0] eff_gain;
   pat_sel_e         eff_sel;

   logic             s1_fv, s1_lv;
   logic [PIX_W-1:0] s1_val, s1_add;

   always_ff @(posedge clk) begin
      if (!rst_n) fv_q <= 1'b0;
      else        fv_q <= in_fv;
   end
   assign frame_start = in_fv && !fv_q;

   pfc_frame_regs #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .cfg_sub    (cfg_black_sub),
      .cfg_gain   (cfg_gain),
      .cfg_add    (cfg_black_add),
      .cfg_sel    (pat_sel_e'(cfg_pat_sel)),
      .cfg_level  (cfg_pat_level),
      .eff_sub    (eff_sub),
      .eff_gain   (eff_gain),
      .eff_add    (eff_add),
      .eff_sel    (eff_sel),
      .eff_level  (eff_level)
   );

   pfc_gain_stage #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_gain (
      .pix   (in_pix),
      .black (eff_sub),
      .gain  (eff_gain),
      .result(cam_pix)
   );

   pfc_pattern_gen #(.PIX_W(PIX_W), .CNT_W(CNT_W), .BAR_SHIFT(BAR_SHIFT),
                     .NUM_BARS(NUM_BARS)) u_pat (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_fv  (in_fv),
      .in_lv  (in_lv),
      .sel    (eff_sel),
      .level  (eff_level),
      .pat_pix(pat_pix)
   );

   // Stage 1: offset, gain and source selection
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_fv  <= 1'b0;
         s1_lv  <= 1'b0;
         s1_val <= '0;
         s1_add <= '0;
      end else begin
         s1_fv  <= in_fv;
         s1_lv  <= in_lv;
         s1_val <= (eff_sel == PAT_CAMERA) ? cam_pix : pat_pix;
         s1_add <= eff_add;
      end
   end

   if (POST_ADD_SAT) begin : g_add_sat
      logic [PIX_W:0] wide;
      assign wide     = {1'b0, s1_val} + {1'b0, s1_add};
      assign post_sum = wide[PIX_W] ? '1 : wide[PIX_W-1:0];
   end else begin : g_add_wrap
      assign post_sum = s1_val + s1_add;
   end

   // Stage 2: post offset and output
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_fv  <= 1'b0;
         out_lv  <= 1'b0;
         out_pix <= '0;
      end else begin
         out_fv  <= s1_fv;
         out_lv  <= s1_lv;
         out_pix <= s1_lv ? post_sum : '0;
      end
   end
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
   parameter int PIX_W     = 10,
   parameter int GAIN_W    = 8,
   parameter int GAIN_FRAC = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_fv,
   input logic              in_lv,
   input logic              out_fv,
   input logic              out_lv,
   input logic [PIX_W-1:0]  out_pix,
   input logic              frame_start,
   input logic [GAIN_W-1:0] eff_gain,
   input logic [PIX_W-1:0]  eff_sub,
   input logic [PIX_W-1:0]  eff_add
);
   logic [1:0] since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_fv_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (out_fv == $past(in_fv, 2)));

   assert_lv_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (out_lv == $past(in_lv, 2)));

   assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_lv |-> (out_pix == '0));

   assert_gain_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eff_gain >= GAIN_W'(1 << GAIN_FRAC));

   assert_hold_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst >= 2'd1) && in_fv && !frame_start) |->
         ($stable(eff_gain) && $stable(eff_sub) && $stable(eff_add)));
endmodule

bind pix_front_cond pfc_checker #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_fv      (in_fv),
   .in_lv      (in_lv),
   .out_fv     (out_fv),
   .out_lv     (out_lv),
   .out_pix    (out_pix),
   .frame_start(frame_start),
   .eff_gain   (eff_gain),
   .eff_sub    (eff_sub),
   .eff_add    (eff_add)
);

// File: tb/tb_pix_front_cond.sv
module tb_pix_front_cond;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_fv, in_lv;
   logic [9:0] in_pix, cfg_black_sub, cfg_black_add, cfg_pat_level;
   logic [7:0] cfg_gain;
   logic [1:0] cfg_pat_sel;
   logic       out_fv, out_lv;
   logic [9:0] out_pix;

   always #2 clk = ~clk;

   pix_front_cond dut (
      .clk(clk), .rst_n(rst_n), .in_fv(in_fv), .in_lv(in_lv), .in_pix(in_pix),
      .cfg_black_sub(cfg_black_sub), .cfg_gain(cfg_gain), .cfg_black_add(cfg_black_add),
      .cfg_pat_sel(cfg_pat_sel), .cfg_pat_level(cfg_pat_level),
      .out_fv(out_fv), .out_lv(out_lv), .out_pix(out_pix)
   );

   int    checks = 0, fails = 0;
   bit    running = 0, finished = 0;
   int    exp_q[$];
   string tag_q[$];
   string cur_tag;
   // model copy of the per-frame settings
   int    m_sub, m_gain, m_add, m_sel, m_level;
   bit    prev_fv = 0;
   logic  h_fv1, h_fv2, h_lv1, h_lv2;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sat(int v);
      return (v > 1023) ? 1023 : v;
   endfunction

   function automatic int model(int pix, int col, int line);
      int v, d, g;
      case (m_sel)
         0: begin
            d = (pix > m_sub) ? pix - m_sub : 0;            // R4
            g = (m_gain < 32) ? 32 : m_gain;                // R5
            v = sat((d * g) >> 5);                          // R6
         end
         1: v = (((col >> 3) % 8) * 1023) / 7;              // R9
         2: v = (col + line) % 1024;                        // R10
         default: v = m_level;                              // R8
      endcase
      return sat(v + m_add);                                // R7
   endfunction

   task automatic drive(bit fv, bit lv, int pix, int col, int line);
      @(negedge clk);
      in_fv  = fv;
      in_lv  = lv;
      in_pix = 10'(pix);
      if (fv && !prev_fv) begin   // R11 capture point
         m_sub = cfg_black_sub; m_gain = cfg_gain; m_add = cfg_black_add;
         m_sel = cfg_pat_sel;   m_level = cfg_pat_level;
      end
      prev_fv = fv;
      if (lv) begin
         exp_q.push_back(model(pix, col, line));
         tag_q.push_back(cur_tag);
      end
   endtask

   task automatic set_cfg(int sub, int gain, int add, int sel, int level);
      cfg_black_sub = 10'(sub); cfg_gain = 8'(gain); cfg_black_add = 10'(add);
      cfg_pat_sel = 2'(sel);    cfg_pat_level = 10'(level);
   endtask

   task automatic run_frame(int lines, int ppl, int seed, bit chg,
                            int nsub, int ngain, int nadd, int nsel);
      drive(1, 0, 0, 0, 0);
      drive(1, 0, 0, 0, 0);
      for (int ln = 0; ln < lines; ln++) begin
         for (int c = 0; c < ppl; c++)
            drive(1, 1, (seed * 37 + ln * 113 + c * 29) % 1024, c, ln);
         if (chg && ln == 0) set_cfg(nsub, ngain, nadd, nsel, 0);
         for (int g = 0; g < 3; g++) drive(1, 0, 0, 0, 0);
      end
      for (int g = 0; g < 4; g++) drive(0, 0, 0, 0, 0);
   endtask

   always @(posedge clk) begin
      h_fv2 <= h_fv1; h_fv1 <= in_fv;
      h_lv2 <= h_lv1; h_lv1 <= in_lv;
   end

   always @(negedge clk) begin
      if (running) begin
         check("R2 fv delay", int'(out_fv), int'(h_fv2));
         check("R2 lv delay", int'(out_lv), int'(h_lv2));
         if (out_lv) begin
            if (exp_q.size() == 0)
               check("R2 unexpected pixel", 1, 0);
            else
               check(tag_q.pop_front(), int'(out_pix), exp_q.pop_front());
         end else begin
            check("R3 idle pixel", int'(out_pix), 0);
         end
      end
   end

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      rst_n = 0; in_fv = 0; in_lv = 0; in_pix = 10'd700;
      set_cfg(0, 32, 0, 0, 0);
      repeat (4) @(negedge clk);
      check("R1 reset fv", int'(out_fv), 0);
      check("R1 reset lv", int'(out_lv), 0);
      check("R1 reset pix", int'(out_pix), 0);
      @(negedge clk);
      rst_n = 1;
      in_pix = '0;
      repeat (3) @(negedge clk);
      running = 1;

      cur_tag = "R4 black clamp";
      set_cfg(64, 32, 0, 0, 0);
      run_frame(3, 16, 1, 0, 0, 0, 0, 0);

      cur_tag = "R5 low gain code";
      set_cfg(0, 10, 0, 0, 0);
      run_frame(2, 16, 2, 0, 0, 0, 0, 0);

      cur_tag = "R6 gain saturate";
      set_cfg(16, 80, 0, 0, 0);
      run_frame(3, 20, 3, 0, 0, 0, 0, 0);

      cur_tag = "R7 post add";
      set_cfg(0, 32, 300, 0, 0);
      run_frame(2, 20, 4, 0, 0, 0, 0, 0);

      cur_tag = "R9 colour bars";
      set_cfg(0, 32, 0, 1, 0);
      run_frame(2, 70, 5, 0, 0, 0, 0, 0);

      cur_tag = "R10 ramp";
      set_cfg(0, 32, 0, 2, 0);
      run_frame(3, 20, 6, 0, 0, 0, 0, 0);

      cur_tag = "R8 flat level";
      set_cfg(0, 32, 20, 3, 500);
      run_frame(2, 10, 7, 0, 0, 0, 0, 0);

      cur_tag = "R11 mid-frame change ignored";
      set_cfg(0, 32, 0, 0, 0);
      run_frame(3, 16, 8, 1, 500, 255, 200, 0);

      cur_tag = "R11 next frame applies";
      run_frame(2, 16, 9, 0, 0, 0, 0, 0);

      repeat (6) @(negedge clk);
      running = 0;
      check("R2 all pixels delivered", exp_q.size(), 0);
      report();
   end
endmodule